// File: doc/BRIEF.md
# Two-Stage Global-History Branch Direction Predictor

This block predicts whether a fetched branch will be taken, for a front end that generates an address, spends two cycles in cache access and decides the next fetch in the following stage. A fetch address is hashed with a global history of recent branch outcomes to select one 2-bit saturating counter in a large table. The table read is spread over the two access cycles, so the array may be big and slow. The registered decision appears in the decision stage. A taken prediction raises a redirect that carries the target supplied with the fetch back to address generation.

Resolved branches return through an update port. The port gives the table index that the prediction used, the actual outcome, a misprediction flag and the history snapshot that travelled with the branch. The counter is moved one step toward the outcome. The history either shifts in the outcome or, after a misprediction, is rebuilt from the snapshot. After reset a sweep sets every counter to weakly not-taken before the predictor accepts traffic.

Top module: `gshare_bp`

## Requirements
- R1: The table index is fetch_addr[WORD_LSB +: IDX_W] XOR the global history register. pred_index and pred_hist report the index and the history value used.
- R2: A fetch presented in cycle c, and accepted, shows pred_valid=1 with its own target in cycle c+3. In every other cycle pred_valid is 0.
- R3: pred_taken is bit 1 of the selected counter (values 2 and 3 mean taken). pred_redirect is 1 exactly when a valid prediction is taken, and pred_target then carries the fetch's target.
- R4: After reset, init_done stays 0 for 2^IDX_W cycles while every counter is set to 01. Fetches and updates presented while init_done is 0 are ignored: they produce no prediction and alter neither counters nor history.
- R5: An update adds 1 to the indexed counter on taken and subtracts 1 on not-taken. The counter saturates at 3 and at 0.
- R6: Updates to the same index in consecutive cycles all take effect, with none lost.
- R7: An update without misprediction sets the history to {history[IDX_W-2:0], upd_taken}, so bit 0 holds the newest outcome.
- R8: An update with upd_mispredict=1 sets the history to {upd_hist[IDX_W-2:0], upd_taken}.
- R9: When a fetch and an update are presented in the same cycle and reach the same index, the prediction uses the counter value from before that update. A fetch one cycle later sees the new value.
- R10: Reset clears the history to 0 and drives pred_valid, pred_redirect and init_done to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | output | 1 | Table sweep finished; traffic accepted |
| fetch_valid | input | 1 | Fetch address present this cycle |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_target | input | ADDR_W | Branch target for this fetch |
| pred_valid | output | 1 | Prediction present (third cycle after fetch) |
| pred_taken | output | 1 | Predicted direction |
| pred_redirect | output | 1 | Redirect fetch to pred_target |
| pred_target | output | ADDR_W | Target of the predicted fetch |
| pred_index | output | IDX_W | Table index used, carried with the branch |
| pred_hist | output | IDX_W | History used, carried as repair snapshot |
| upd_valid | input | 1 | Resolved branch present |
| upd_index | input | IDX_W | Index that was used to predict it |
| upd_taken | input | 1 | Actual outcome |
| upd_mispredict | input | 1 | Prediction was wrong; repair history |
| upd_hist | input | IDX_W | History snapshot carried with the branch |

## Verification
On every cycle, the assertions check the fixed three-cycle relation between an accepted fetch and its prediction: that the target is carried along, that the reported index and history XOR back to the fetch's word address, and that a redirect implies a taken prediction. They also check both ways of updating the history and the silence of the outputs during the sweep. Counter values can only be observed through later predictions, so the bench scenarios alone show saturation at both ends, back-to-back updates to one index, the read-before-update order on a collision, and that an update arriving during the sweep is discarded.

// File: rtl/gshare_bp_pkg.sv
package gshare_bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  // one saturating step toward the resolved outcome
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'd1;
    else    r = (c == 2'b00) ? c : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int HW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_go,
  input  logic          upd_taken,
  input  logic          upd_repair,
  input  logic [HW-1:0] upd_snap,
  output logic [HW-1:0] ghr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ghr <= '0;
    end else if (upd_go) begin
      if (upd_repair) ghr <= {upd_snap[HW-2:0], upd_taken};
      else            ghr <= {ghr[HW-2:0], upd_taken};
    end
  end
endmodule

// File: rtl/gbp_table.sv
module gbp_table
  import gshare_bp_pkg::*;
#(
  parameter int IDX_W = 14,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b_data,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_data
);
  ctr_t mem [DEPTH];

  // registered reads, read-before-write on address collision
  always_ff @(posedge clk) begin
    rd_a_data <= mem[rd_a_idx];
    rd_b_data <= mem[rd_b_idx];
    if (we) mem[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/gbp_update.sv
module gbp_update
  import gshare_bp_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic             in_taken,
  input  ctr_t             rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output ctr_t             wr_data
);
  logic             u_valid;
  logic [IDX_W-1:0] u_idx;
  logic             u_taken;
  logic             u_byp;
  ctr_t             u_bypv;
  ctr_t             u_cur;
  ctr_t             u_new;
  logic             u_hit;

  // the table read lags one cycle; forward the write landing on the same edge
  assign u_cur = u_byp ? u_bypv : rd_data;
  assign u_new = ctr_step(u_cur, u_taken);
  assign u_hit = u_valid && (u_idx == in_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      u_valid <= 1'b0;
      u_byp   <= 1'b0;
    end else begin
      u_valid <= in_valid;
      u_byp   <= u_hit;
    end
    u_idx   <= in_idx;
    u_taken <= in_taken;
    u_bypv  <= u_new;
  end

  assign wr_en   = u_valid;
  assign wr_idx  = u_idx;
  assign wr_data = u_new;
endmodule

// File: rtl/gshare_bp.sv
module gshare_bp
  import gshare_bp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 11,
  parameter int WORD_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic              init_done,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] fetch_target,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              pred_redirect,
  output logic [ADDR_W-1:0] pred_target,
  output logic [IDX_W-1:0]  pred_index,
  output logic [IDX_W-1:0]  pred_hist,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_index,
  input  logic              upd_taken,
  input  logic              upd_mispredict,
  input  logic [IDX_W-1:0]  upd_hist
);
  logic             sweeping;
  logic [IDX_W-1:0] sweep_idx;
  logic [IDX_W-1:0] ghr;
  logic             fetch_go, upd_go;
  logic [IDX_W-1:0] f_idx;

  logic             s1_v, s2_v;
  logic [IDX_W-1:0] s1_idx, s2_idx, s1_hist, s2_hist;
  logic [ADDR_W-1:0] s1_tgt, s2_tgt;

  ctr_t             a_cnt, b_cnt;
  logic             u_we, t_we;
  logic [IDX_W-1:0] u_widx, t_widx;
  ctr_t             u_wdata, t_wdata;

  assign init_done = ~sweeping;
  assign fetch_go  = fetch_valid & ~sweeping;
  assign upd_go    = upd_valid & ~sweeping;
  assign f_idx     = fetch_addr[WORD_LSB +: IDX_W] ^ ghr;

  // reset sweep: one counter per cycle set to weakly not-taken
  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping  <= 1'b1;
      sweep_idx <= '0;
    end else if (sweeping) begin
      sweep_idx <= sweep_idx + 1'b1;
      if (&sweep_idx) sweeping <= 1'b0;
    end
  end

  gbp_history #(.HW(IDX_W)) hist_i (
    .clk(clk), .rst(rst), .upd_go(upd_go), .upd_taken(upd_taken),
    .upd_repair(upd_mispredict), .upd_snap(upd_hist), .ghr(ghr)
  );

  gbp_update #(.IDX_W(IDX_W)) upd_i (
    .clk(clk), .rst(rst), .in_valid(upd_go), .in_idx(upd_index),
    .in_taken(upd_taken), .rd_data(b_cnt),
    .wr_en(u_we), .wr_idx(u_widx), .wr_data(u_wdata)
  );

  assign t_we    = sweeping | u_we;
  assign t_widx  = sweeping ? sweep_idx : u_widx;
  assign t_wdata = sweeping ? CTR_WEAK_NT : u_wdata;

  gbp_table #(.IDX_W(IDX_W)) tbl_i (
    .clk(clk), .rd_a_idx(s1_idx), .rd_a_data(a_cnt),
    .rd_b_idx(upd_index), .rd_b_data(b_cnt),
    .we(t_we), .wr_idx(t_widx), .wr_data(t_wdata)
  );

  // address stage -> first access cycle -> second access cycle -> decision
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v          <= 1'b0;
      s2_v          <= 1'b0;
      pred_valid    <= 1'b0;
      pred_taken    <= 1'b0;
      pred_redirect <= 1'b0;
      pred_hist     <= '0;
    end else begin
      s1_v          <= fetch_go;
      s2_v          <= s1_v;
      pred_valid    <= s2_v;
      pred_taken    <= s2_v & a_cnt[1];
      pred_redirect <= s2_v & a_cnt[1];
      pred_hist     <= s2_hist;
    end
    s1_idx      <= f_idx;
    s1_hist     <= ghr;
    s1_tgt      <= fetch_target;
    s2_idx      <= s1_idx;
    s2_hist     <= s1_hist;
    s2_tgt      <= s1_tgt;
    pred_index  <= s2_idx;
    pred_target <= s2_tgt;
  end
endmodule

// File: rtl/gshare_bp_chk.sv
module gshare_bp_chk #(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 11,
  parameter int WORD_LSB = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              init_done,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] fetch_target,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              pred_redirect,
  input logic [ADDR_W-1:0] pred_target,
  input logic [IDX_W-1:0]  pred_index,
  input logic [IDX_W-1:0]  pred_hist,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic              upd_mispredict,
  input logic [IDX_W-1:0]  upd_hist,
  input logic [IDX_W-1:0]  ghr
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    since_rst == 2'd3 |-> pred_valid == $past(fetch_valid && init_done, 3));

  a_r2_target: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && pred_valid) |-> pred_target == $past(fetch_target, 3));

  a_r1_index: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && pred_valid) |->
      (pred_index ^ pred_hist) == $past(fetch_addr[WORD_LSB +: IDX_W], 3));

  a_r3_redirect: assert property (@(posedge clk) disable iff (rst)
    pred_redirect |-> (pred_valid && pred_taken));

  a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !pred_valid);

  a_r7_shift: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && init_done && !upd_mispredict) |=>
      ghr == {$past(ghr[IDX_W-2:0]), $past(upd_taken)});

  a_r8_repair: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && init_done && upd_mispredict) |=>
      ghr == {$past(upd_hist[IDX_W-2:0]), $past(upd_taken)});
endmodule

bind gshare_bp gshare_bp_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_LSB(WORD_LSB)
) chk_i (
  .clk(clk), .rst(rst), .init_done(init_done),
  .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_target(fetch_target),
  .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_redirect(pred_redirect),
  .pred_target(pred_target), .pred_index(pred_index), .pred_hist(pred_hist),
  .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_mispredict(upd_mispredict),
  .upd_hist(upd_hist), .ghr(ghr)
);

// File: tb/gshare_bp_tb_top.sv
`timescale 1ns/1ps
module gshare_bp_tb_top;
  localparam int ADDR_W   = 32;
  localparam int IDX_W    = 11;
  localparam int WORD_LSB = 2;
  localparam int DEPTH    = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              init_done;
  logic              fetch_valid = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic [ADDR_W-1:0] fetch_target = '0;
  logic              pred_valid, pred_taken, pred_redirect;
  logic [ADDR_W-1:0] pred_target;
  logic [IDX_W-1:0]  pred_index, pred_hist;
  logic              upd_valid = 1'b0;
  logic [IDX_W-1:0]  upd_index = '0;
  logic              upd_taken = 1'b0;
  logic              upd_mispredict = 1'b0;
  logic [IDX_W-1:0]  upd_hist = '0;

  always #10 clk = ~clk;

  gshare_bp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_LSB(WORD_LSB)) dut_i (
    .clk(clk), .rst(rst), .init_done(init_done),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_target(fetch_target),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_redirect(pred_redirect),
    .pred_target(pred_target), .pred_index(pred_index), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_index(upd_index), .upd_taken(upd_taken),
    .upd_mispredict(upd_mispredict), .upd_hist(upd_hist)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic [1:0]        mtbl [DEPTH];
  logic [IDX_W-1:0]  mghr;
  logic [IDX_W-1:0]  recent [4];

  bit                exp_v   [4];
  logic [IDX_W-1:0]  exp_idx [4];
  logic [IDX_W-1:0]  exp_hist[4];
  logic [1:0]        exp_ctr [4];
  logic [ADDR_W-1:0] exp_tgt [4];
  string             exp_tag [4];

  function automatic logic [1:0] sat_next(logic [1:0] c, bit up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic chk(string req, string what, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // fetch address whose index under the current model history is k
  function automatic logic [ADDR_W-1:0] addr_for(logic [IDX_W-1:0] k);
    logic [ADDR_W-1:0] a;
    a = $urandom;
    a[WORD_LSB +: IDX_W] = k ^ mghr;
    return a;
  endfunction

  // one cycle: check the prediction due now, drive, then advance the model
  task automatic step(bit fv, logic [ADDR_W-1:0] fa, logic [ADDR_W-1:0] ft,
                      bit uv, logic [IDX_W-1:0] ui, bit ut, bit um,
                      logic [IDX_W-1:0] uh, string tag);
    int s;
    int w;
    bit live;
    s = (cyc + 1) % 4;
    w = cyc % 4;
    if (exp_v[s]) begin
      chk({exp_tag[s], "/R2"}, "pred_valid", pred_valid, 1);
      chk({exp_tag[s], "/R2"}, "pred_target", pred_target, exp_tgt[s]);
      chk({exp_tag[s], "/R1"}, "pred_index", pred_index, exp_idx[s]);
      chk({exp_tag[s], "/R7"}, "pred_hist", pred_hist, exp_hist[s]);
      chk({exp_tag[s], "/R3"}, "pred_taken", pred_taken, exp_ctr[s][1]);
      chk({exp_tag[s], "/R3"}, "pred_redirect", pred_redirect, exp_ctr[s][1]);
    end else begin
      chk({exp_tag[s], "/R2"}, "pred_valid idle", pred_valid, 0);
      chk({exp_tag[s], "/R3"}, "pred_redirect idle", pred_redirect, 0);
    end
    live = init_done;
    fetch_valid = fv; fetch_addr = fa; fetch_target = ft;
    upd_valid = uv; upd_index = ui; upd_taken = ut;
    upd_mispredict = um; upd_hist = uh;
    exp_v[w]   = fv && live;
    exp_idx[w] = fa[WORD_LSB +: IDX_W] ^ mghr;
    exp_hist[w] = mghr;
    exp_ctr[w] = mtbl[fa[WORD_LSB +: IDX_W] ^ mghr];
    exp_tgt[w] = ft;
    exp_tag[w] = tag;
    if (fv && live) begin
      recent[cyc % 4] = fa[WORD_LSB +: IDX_W] ^ mghr;
    end
    if (uv && live) begin
      mtbl[ui] = sat_next(mtbl[ui], ut);
      mghr = um ? {uh[IDX_W-2:0], ut} : {mghr[IDX_W-2:0], ut};
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, '0, 0, 0, '0, tag);
  endtask

  task automatic fetch_at(logic [IDX_W-1:0] k, string tag);
    logic [ADDR_W-1:0] a;
    a = addr_for(k);
    step(1, a, $urandom, 0, '0, 0, 0, '0, tag);
  endtask

  task automatic upd_at(logic [IDX_W-1:0] k, bit t, string tag);
    step(0, '0, '0, 1, k, t, 0, '0, tag);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [IDX_W-1:0] k;
    logic [ADDR_W-1:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mtbl[i] = 2'b01;
    mghr = '0;
    for (int i = 0; i < 4; i++) begin
      exp_v[i] = 0; exp_tag[i] = "R10"; recent[i] = '0;
    end

    // R10: state held in reset
    repeat (4) @(negedge clk);
    chk("R10", "pred_valid in reset", pred_valid, 0);
    chk("R10", "pred_redirect in reset", pred_redirect, 0);
    chk("R10", "init_done in reset", init_done, 0);
    chk("R10", "pred_hist in reset", pred_hist, 0);
    rst = 1'b0;

    // R4: sweep; traffic offered meanwhile must be dropped
    for (int i = 0; i < DEPTH + 8 && !init_done; i++) begin
      a = $urandom;
      if (i == 100) step(1, a, $urandom, 1, '0, 1, 0, '0, "R4");
      else          step(1, a, $urandom, 0, '0, 0, 0, '0, "R4");
    end
    chk("R4", "init_done after sweep", init_done, 1);
    fetch_at('0, "R4");   // entry 0 must still be weakly not-taken, history 0
    idle(3, "R4");

    // R5 and R6: back-to-back taken updates saturate at 3
    k = 11'd37;
    for (int i = 0; i < 4; i++) upd_at(k, 1, "R6");
    fetch_at(k, "R5");
    upd_at(k, 0, "R5");
    fetch_at(k, "R5");            // 3 -> 2, still taken
    for (int i = 0; i < 4; i++) upd_at(k, 0, "R6");
    fetch_at(k, "R5");            // saturated at 0
    upd_at(k, 1, "R5");
    fetch_at(k, "R5");            // 0 -> 1, not taken
    idle(3, "R5");

    // R9: fetch and update hit the same index in one cycle
    k = 11'd300;
    a = addr_for(k);
    step(1, a, $urandom, 1, k, 1, 0, '0, "R9");  // sees 01
    fetch_at(k, "R9");                          // sees 10
    a = addr_for(k);
    step(1, a, $urandom, 1, k, 0, 0, '0, "R9"); // sees 10
    fetch_at(k, "R9");                          // sees 01
    idle(3, "R9");

    // R8: repair from snapshot, then R7 shifts on top of it
    step(0, '0, '0, 1, 11'd5, 1, 1, 11'h5A3, "R8");
    fetch_at(11'd9, "R8");
    step(0, '0, '0, 1, 11'd6, 0, 0, 11'h7FF, "R7");
    fetch_at(11'd9, "R7");
    step(0, '0, '0, 1, 11'd7, 0, 1, 11'h000, "R8");
    fetch_at(11'd9, "R8");
    idle(3, "R8");

    // random mix with index reuse to provoke collisions and forwarding
    for (int i = 0; i < 4000; i++) begin
      bit fv, uv, ut, um;
      logic [IDX_W-1:0] fk, uk;
      fv = ($urandom % 4) != 0;
      uv = ($urandom % 2) != 0;
      ut = ($urandom % 3) != 0;
      um = ($urandom % 5) == 0;
      fk = (($urandom % 3) == 0) ? IDX_W'($urandom) : recent[$urandom % 4];
      uk = (($urandom % 4) == 0) ? fk : recent[$urandom % 4];
      a = addr_for(fk);
      step(fv, a, $urandom, uv, uk, ut, um, IDX_W'($urandom), "R1");
    end
    idle(4, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule